// File: doc/BRIEF.md
# ATA Task-File Command and Status Controller

This block is the register front end of a single ATA disk device. A host reaches it through an eight-entry I/O window with separate read and write strobes. Through that window the host loads the feature, sector-count, LBA and device bytes, then writes an opcode. The block keeps the status byte and the error byte and drives the interrupt request line. It runs three kinds of command itself: IDENTIFY, FLUSH CACHE and the abort path for opcodes it does not support.

IDENTIFY returns 256 words that the block builds from its parameters: a serial string, a revision string, the capacity and feature flags. No memory is used for this. FLUSH CACHE keeps the device busy for a fixed number of cycles set by a parameter. The block does not move DMA data. For the DMA opcodes it sends a one-cycle start pulse and a direction bit to an external engine, then waits for that engine to report done and say whether the transfer failed.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset:
  - status (offset 7) reads 0x40;
  - error (offset 1) reads 0x00;
  - the interrupt line and the DMA start pulse are low.
- R2: Offsets 2 to 6 read back the last byte written to them in bits 7:0, with bits 15:8 zero. A write to offset 1 loads the feature byte. A read of offset 1 returns the error byte and not the feature byte.
- R3: IDENTIFY (0xEC), written while device 0 is selected, has this sequence:
  - On the next clock, status becomes 0x48 (ready plus data request) and the interrupt is raised.
  - Status stays 0x48 before each of 256 reads of offset 0.
  - After the 256th read, status is 0x40.
- R4: IDENTIFY words are as follows:
  - Word 0 is 0x0040.
  - Words 10–19 hold the 20-character serial string, two characters per word, the first character in the high byte.
  - Words 23–26 hold the 8-character revision string in the same packing.
  - Word 49 is 0x0200 (LBA supported).
  - Words 60 and 61 hold the low 16 bits and the upper 12 bits of the 28-bit capacity.
  - Word 85 is 0x0020 (write cache enabled).
  - Every other word is 0.
- R5: FLUSH CACHE (0xE7) has this sequence:
  - Status reads 0xC0 (busy plus ready) for exactly FLUSH_CYCLES clock cycles after the command edge.
  - Status then reads 0x40 and the interrupt is raised.
- R6: A read strobe on offset 7 deasserts the interrupt at that clock edge. A read of offset 1 leaves the interrupt unchanged.
- R7: DMA opcodes are READ DMA (0xC8), WRITE DMA (0xCA) and data-set management (0x06) with feature bit 0 set. For each of them:
  - `dma_start` is high for exactly the one cycle after the command edge.
  - `dma_to_mem` is 1 only for 0xC8.
  - Status reads 0xC0 until `dma_done`.
  - At the `dma_done` edge the command completes with the interrupt raised. Status becomes 0x40, or 0x41 with error 0x04 if `dma_fail` was high.
- R8: The abort path is taken for any other opcode, and for 0x06 with feature bit 0 clear. It completes on the command edge with status 0x41, error 0x04 (abort) and the interrupt raised.
- R9: While device-register bit 4 is 1 (device 1 selected), command writes are ignored: status and the interrupt do not change.
- R10: While status shows busy or data request, command writes are ignored. While busy, writes to offsets 1 to 6 are ignored.
- R11: An accepted command clears the error byte and the status ERR bit on its command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 3 | Register offset in the I/O window |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| reg_wdata | input | 16 | Write data (8-bit registers use bits 7:0) |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| intrq | output | 1 | Interrupt request |
| dma_start | output | 1 | One-cycle start pulse to the DMA engine |
| dma_to_mem | output | 1 | DMA direction: 1 = device to memory |
| dma_done | input | 1 | DMA engine finished |
| dma_fail | input | 1 | Qualifies `dma_done`: transfer or range fault |

## Verification
The bench builds the controller with a 12-cycle flush, so the busy window can be counted cycle by cycle and compared with the parameter. It also sets a 20-character serial, an 8-character revision and a capacity above 16 bits. These values put the high/low byte packing of every string word and the split of the capacity across two words in reach of the word-by-word IDENTIFY check. The DMA handshake is driven with random wait times and random failure flags. Unknown opcodes are drawn at random, so both completion codes and the abort path are exercised alongside the directed device-1 and busy-time cases.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  // register window offsets
  localparam logic [2:0] A_DATA    = 3'd0;
  localparam logic [2:0] A_ERRFEAT = 3'd1;
  localparam logic [2:0] A_COUNT   = 3'd2;
  localparam logic [2:0] A_LBA0    = 3'd3;
  localparam logic [2:0] A_LBA1    = 3'd4;
  localparam logic [2:0] A_LBA2    = 3'd5;
  localparam logic [2:0] A_DEVSEL  = 3'd6;
  localparam logic [2:0] A_CMDSTAT = 3'd7;

  // opcodes
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;
  localparam logic [7:0] OP_FLUSH    = 8'hE7;
  localparam logic [7:0] OP_RD_DMA   = 8'hC8;
  localparam logic [7:0] OP_WR_DMA   = 8'hCA;
  localparam logic [7:0] OP_DSM      = 8'h06;

  // bit positions
  localparam int DEV1_BIT  = 4;
  localparam int TRIM_BIT  = 0;

  // identify buffer geometry
  localparam int ID_WORDS = 256;
  localparam int ID_IW    = $clog2(ID_WORDS);

  // taskfile byte registers live at offsets 1..6
  localparam int TF_FIRST = 1;
  localparam int TF_LAST  = 6;
  localparam int TF_BYTES = TF_LAST - TF_FIRST + 1;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_PIO_IN = 2'd1,
    S_FLUSH  = 2'd2,
    S_DMA    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            addr,
  input  logic [7:0]            wdata,
  output logic [TF_BYTES*8-1:0] tf_bytes
);

  for (genvar a = TF_FIRST; a <= TF_LAST; a++) begin : g_byte
    logic [7:0] byte_q;
    logic       byte_en;

    assign byte_en = wr_en && (addr == 3'(a));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wdata;
      end
    end

    assign tf_bytes[(a-TF_FIRST)*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/ata_tf_idgen.sv
module ata_tf_idgen
  import ata_tf_pkg::*;
#(
  parameter logic [27:0]  CAPACITY   = 28'h0100000,
  parameter logic [159:0] SERIAL_STR = "UNSET SERIAL NUMBER ",
  parameter logic [63:0]  REV_STR    = "1.0     "
) (
  input  logic [ID_IW-1:0] idx,
  output logic [15:0]      word
);

  localparam int SER_FIRST = 10;
  localparam int SER_LAST  = SER_FIRST + 160/16 - 1;
  localparam int REV_FIRST = 23;
  localparam int REV_LAST  = REV_FIRST + 64/16 - 1;

  int unsigned wi;

  always_comb begin
    wi   = 32'(idx);
    word = '0;
    if (wi == 0) begin
      word = 16'h0040;
    end else if (wi >= SER_FIRST && wi <= SER_LAST) begin
      word = SERIAL_STR[159 - 16*(wi - SER_FIRST) -: 16];
    end else if (wi >= REV_FIRST && wi <= REV_LAST) begin
      word = REV_STR[63 - 16*(wi - REV_FIRST) -: 16];
    end else if (wi == 49) begin
      word = 16'h0200;
    end else if (wi == 60) begin
      word = CAPACITY[15:0];
    end else if (wi == 61) begin
      word = {4'h0, CAPACITY[27:16]};
    end else if (wi == 85) begin
      word = 16'h0020;
    end
  end

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int unsigned FLUSH_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       opcode,
  input  logic             dev1_sel,
  input  logic             trim_en,
  input  logic             data_rd,
  input  logic             stat_rd,
  input  logic             dma_done,
  input  logic             dma_fail,
  output logic             bsy,
  output logic             drq,
  output logic             err,
  output logic             abrt,
  output logic             intrq,
  output logic             dma_start,
  output logic             dma_dir,
  output logic [ID_IW-1:0] id_idx
);

  localparam int CW = (FLUSH_CYCLES < 2) ? 1 : $clog2(FLUSH_CYCLES);
  localparam logic [CW-1:0] CNT_LOAD = CW'(FLUSH_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic [ID_IW-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             err_q, err_d, abrt_q, abrt_d;
  logic             irq_q, irq_d, irq_set, irq_clr;
  logic             start_q, start_d;
  logic             dir_q, dir_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    err_d   = err_q;
    abrt_d  = abrt_q;
    start_d = 1'b0;
    dir_d   = dir_q;
    irq_set = 1'b0;
    irq_clr = stat_rd;

    case (state_q)
      S_IDLE: begin
        if (cmd_wr && !dev1_sel) begin
          irq_clr = 1'b1;
          err_d   = 1'b0;
          abrt_d  = 1'b0;
          case (opcode)
            OP_IDENTIFY: begin
              state_d = S_PIO_IN;
              idx_d   = '0;
              idx_en  = 1'b1;
              irq_set = 1'b1;
            end
            OP_FLUSH: begin
              state_d = S_FLUSH;
              cnt_d   = CNT_LOAD;
              cnt_en  = 1'b1;
            end
            OP_RD_DMA: begin
              state_d = S_DMA;
              start_d = 1'b1;
              dir_d   = 1'b1;
            end
            OP_WR_DMA: begin
              state_d = S_DMA;
              start_d = 1'b1;
              dir_d   = 1'b0;
            end
            OP_DSM: begin
              if (trim_en) begin
                state_d = S_DMA;
                start_d = 1'b1;
                dir_d   = 1'b0;
              end else begin
                err_d   = 1'b1;
                abrt_d  = 1'b1;
                irq_set = 1'b1;
              end
            end
            default: begin
              err_d   = 1'b1;
              abrt_d  = 1'b1;
              irq_set = 1'b1;
            end
          endcase
        end
      end
      S_PIO_IN: begin
        if (data_rd) begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
          if (idx_q == '1) begin
            state_d = S_IDLE;
          end
        end
      end
      S_FLUSH: begin
        if (cnt_q == '0) begin
          state_d = S_IDLE;
          irq_set = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_DMA: begin
        if (dma_done) begin
          state_d = S_IDLE;
          irq_set = 1'b1;
          err_d   = dma_fail;
          abrt_d  = dma_fail;
        end
      end
      default: state_d = S_IDLE;
    endcase

    irq_d = irq_set | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
      abrt_q  <= 1'b0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      abrt_q  <= abrt_d;
      irq_q   <= irq_d;
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign bsy       = (state_q == S_FLUSH) || (state_q == S_DMA);
  assign drq       = (state_q == S_PIO_IN);
  assign err       = err_q;
  assign abrt      = abrt_q;
  assign intrq     = irq_q;
  assign dma_start = start_q;
  assign dma_dir   = dir_q;
  assign id_idx    = idx_q;

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int unsigned  FLUSH_CYCLES = 64,
  parameter logic [27:0]  CAPACITY     = 28'h0100000,
  parameter logic [159:0] SERIAL_STR   = "UNSET SERIAL NUMBER ",
  parameter logic [63:0]  REV_STR      = "1.0     "
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        intrq,
  output logic        dma_start,
  output logic        dma_to_mem,
  input  logic        dma_done,
  input  logic        dma_fail
);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic [TF_BYTES*8-1:0] tf_bytes;
  logic                  bsy, drq, err, abrt;
  logic [ID_IW-1:0]      id_idx;
  logic [15:0]           id_word;
  logic [7:0]            status;
  logic [7:0]            error;
  logic                  dev1_sel;

  ata_tf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (reg_wr && !bsy),
    .addr     (reg_addr),
    .wdata    (reg_wdata[7:0]),
    .tf_bytes (tf_bytes)
  );

  assign dev1_sel = tf_bytes[(int'(A_DEVSEL)-TF_FIRST)*8 + DEV1_BIT];

  ata_tf_seq #(
    .FLUSH_CYCLES (FLUSH_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_wr    (reg_wr && (reg_addr == A_CMDSTAT)),
    .opcode    (reg_wdata[7:0]),
    .dev1_sel  (dev1_sel),
    .trim_en   (tf_bytes[(int'(A_ERRFEAT)-TF_FIRST)*8 + TRIM_BIT]),
    .data_rd   (reg_rd && (reg_addr == A_DATA)),
    .stat_rd   (reg_rd && (reg_addr == A_CMDSTAT)),
    .dma_done  (dma_done),
    .dma_fail  (dma_fail),
    .bsy       (bsy),
    .drq       (drq),
    .err       (err),
    .abrt      (abrt),
    .intrq     (intrq),
    .dma_start (dma_start),
    .dma_dir   (dma_to_mem),
    .id_idx    (id_idx)
  );

  ata_tf_idgen #(
    .CAPACITY   (CAPACITY),
    .SERIAL_STR (SERIAL_STR),
    .REV_STR    (REV_STR)
  ) u_idgen (
    .idx  (id_idx),
    .word (id_word)
  );

  // busy, ready, fault, seek-done, request, two obsolete, error
  assign status = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};
  assign error  = {5'b00000, abrt, 2'b00};

  always_comb begin
    case (reg_addr)
      A_DATA:    reg_rdata = drq ? id_word : 16'h0000;
      A_ERRFEAT: reg_rdata = {8'h00, error};
      A_CMDSTAT: reg_rdata = {8'h00, status};
      default:   reg_rdata = {8'h00, tf_bytes[(int'(reg_addr)-TF_FIRST)*8 +: 8]};
    endcase
  end

endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        intrq,
  input logic        dma_start,
  input logic [7:0]  status,
  input logic [7:0]  error,
  input logic        dev1_sel
);

  assert_bsy_drq_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[3]));

  assert_busy_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> (status[6] && !status[5] && !status[0]));

  assert_status_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd7 && !reg_wr && !status[7]) |=> !intrq);

  assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  assert_err_has_abrt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> error[2]);

  assert_dev1_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd7 && dev1_sel && !status[7] && !status[3])
      |=> ($stable(status) && $stable(intrq)));

endmodule

bind ata_taskfile_ctrl ata_tf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .intrq     (intrq),
  .dma_start (dma_start),
  .status    (status),
  .error     (error),
  .dev1_sel  (dev1_sel)
);

// File: tb/tb_ata_taskfile_ctrl.sv
module tb_ata_taskfile_ctrl;

  localparam int unsigned  FLUSH_N = 12;
  localparam logic [27:0]  CAP     = 28'h0ABCDEF;
  localparam logic [159:0] SER     = "SN-0042-TESTBENCH-01";
  localparam logic [63:0]  REV     = "R2.5-b  ";

  logic        clk;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        intrq;
  logic        dma_start;
  logic        dma_to_mem;
  logic        dma_done;
  logic        dma_fail;

  int vectors;
  int miscompares;
  bit finished;

  ata_taskfile_ctrl #(
    .FLUSH_CYCLES (FLUSH_N),
    .CAPACITY     (CAP),
    .SERIAL_STR   (SER),
    .REV_STR      (REV)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .intrq      (intrq),
    .dma_start  (dma_start),
    .dma_to_mem (dma_to_mem),
    .dma_done   (dma_done),
    .dma_fail   (dma_fail)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected identify word per R4
  function automatic logic [15:0] exp_id(input int i);
    if (i == 0)                 return 16'h0040;
    if (i >= 10 && i <= 19)     return SER[159 - 16*(i-10) -: 16];
    if (i >= 23 && i <= 26)     return REV[63 - 16*(i-23) -: 16];
    if (i == 49)                return 16'h0200;
    if (i == 60)                return CAP[15:0];
    if (i == 61)                return {4'h0, CAP[27:16]};
    if (i == 85)                return 16'h0020;
    return 16'h0000;
  endfunction

  function automatic logic is_known(input logic [7:0] op);
    return (op == 8'hEC) || (op == 8'hE7) || (op == 8'hC8) ||
           (op == 8'hCA) || (op == 8'h06);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    peek(3'd7, s);
    while (s[7]) begin
      @(negedge clk);
      peek(3'd7, s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] w;
    vectors = 0;
    miscompares = 0;
    finished = 1'b0;
    void'($urandom(32'd2024));
    reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    dma_done = 0; dma_fail = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(3'd7, v); chk("R1 status", v, 16'h0040);
    peek(3'd1, v); chk("R1 error", v, 16'h0000);
    chk("R1 intrq", {15'h0, intrq}, 16'h0000);
    chk("R1 dma_start", {15'h0, dma_start}, 16'h0000);

    // R2 feature write is not visible on read of offset 1
    wr(3'd1, 16'h00FE);
    rd(3'd1, v); chk("R2 error not feature", v, 16'h0000);

    // R2 random readback
    for (int k = 0; k < 24; k++) begin
      logic [2:0]  a;
      logic [15:0] d;
      a = 3'(2 + ($urandom % 5));
      d = 16'($urandom);
      wr(a, d);
      rd(a, v);
      chk("R2 readback", v, {8'h00, d[7:0]});
    end
    wr(3'd6, 16'h0040);
    rd(3'd6, v); chk("R2 device bit4 clear", {15'h0, v[4]}, 16'h0000);

    // R8 unknown opcodes, random
    for (int k = 0; k < 8; k++) begin
      logic [7:0] op;
      op = 8'($urandom);
      while (is_known(op)) op = 8'($urandom);
      wr(3'd7, {8'h00, op});
      peek(3'd7, v); chk("R8 status", v, 16'h0041);
      peek(3'd1, v); chk("R8 error", v, 16'h0004);
      chk("R8 intrq", {15'h0, intrq}, 16'h0001);
    end

    // R6 error read keeps interrupt, status read clears it
    rd(3'd1, v);
    chk("R6 error read keeps intrq", {15'h0, intrq}, 16'h0001);
    rd(3'd7, v);
    chk("R6 status read clears intrq", {15'h0, intrq}, 16'h0000);

    // R8 DSM with trim bit clear aborts
    wr(3'd1, 16'h0000);
    wr(3'd7, 16'h0006);
    peek(3'd7, v); chk("R8 dsm no trim status", v, 16'h0041);
    peek(3'd1, v); chk("R8 dsm no trim error", v, 16'h0004);
    chk("R8 dsm no trim no start", {15'h0, dma_start}, 16'h0000);

    // R11 accepted flush clears error on its edge; R5 busy window length
    wr(3'd7, 16'h00E7);
    peek(3'd1, v); chk("R11 error cleared", v, 16'h0000);
    peek(3'd7, v); chk("R5 flush status", v, 16'h00C0);
    begin
      int busy_n;
      busy_n = 0;
      while (v[7] && busy_n < 1000) begin
        busy_n++;
        @(negedge clk);
        peek(3'd7, v);
      end
      chk("R5 busy cycles", 16'(busy_n), 16'(FLUSH_N));
    end
    chk("R5 done status", v, 16'h0040);
    chk("R5 intrq", {15'h0, intrq}, 16'h0001);
    rd(3'd7, v);

    // R10 writes during busy are ignored
    wr(3'd3, 16'h0011);
    wr(3'd7, 16'h00E7);
    wr(3'd3, 16'h0099);
    wr(3'd7, 16'h00EC);
    wait_idle();
    peek(3'd7, v); chk("R10 cmd ignored while busy", v, 16'h0040);
    peek(3'd3, v); chk("R10 lba write ignored", v, 16'h0011);
    rd(3'd7, v);

    // R9 device 1 selected: command ignored
    wr(3'd6, 16'h0050);
    wr(3'd7, 16'h00EC);
    peek(3'd7, v); chk("R9 status unchanged", v, 16'h0040);
    chk("R9 no intrq", {15'h0, intrq}, 16'h0000);
    wr(3'd6, 16'h0040);

    // R3/R4 identify
    wr(3'd7, 16'h00EC);
    chk("R3 intrq", {15'h0, intrq}, 16'h0001);
    rd(3'd7, v); chk("R3 first status", v, 16'h0048);
    wr(3'd7, 16'h00E7);
    peek(3'd7, v); chk("R10 cmd ignored during drq", v, 16'h0048);
    for (int i = 0; i < 256; i++) begin
      peek(3'd7, v); chk("R3 status before word", v, 16'h0048);
      rd(3'd0, w);   chk("R4 identify word", w, exp_id(i));
    end
    peek(3'd7, v); chk("R3 status after last word", v, 16'h0040);

    // R7 DMA commands with random wait and fail
    for (int k = 0; k < 9; k++) begin
      logic [7:0] op;
      logic       f;
      int         wt;
      case (k % 3)
        0:       op = 8'hC8;
        1:       op = 8'hCA;
        default: op = 8'h06;
      endcase
      f  = 1'($urandom);
      wt = int'($urandom % 6);
      wr(3'd1, 16'h0001);
      wr(3'd7, {8'h00, op});
      chk("R7 start pulse", {15'h0, dma_start}, 16'h0001);
      chk("R7 direction", {15'h0, dma_to_mem}, {15'h0, (op == 8'hC8)});
      @(negedge clk);
      chk("R7 start one cycle", {15'h0, dma_start}, 16'h0000);
      repeat (wt) @(negedge clk);
      peek(3'd7, v); chk("R7 busy status", v, 16'h00C0);
      dma_done = 1'b1; dma_fail = f;
      @(negedge clk);
      dma_done = 1'b0; dma_fail = 1'b0;
      peek(3'd7, v); chk("R7 done status", v, f ? 16'h0041 : 16'h0040);
      peek(3'd1, v); chk("R7 done error", v, f ? 16'h0004 : 16'h0000);
      chk("R7 intrq", {15'h0, intrq}, 16'h0001);
      rd(3'd7, v);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule